// File: doc/BRIEF.md
# Serial Command Frame Decoder for a Digital Resistor

This block is the slave side of a four-wire serial link that sets the tap position of a digitally controlled resistor. A host pulls the frame select low, clocks command words in most significant bit first on the rising edge of the serial clock, and raises frame select to have the last complete word decoded. The block keeps a 10-bit tap register, a small control register and a power-down flag, and it answers read commands on the serial output during the frame that follows.

Storing the tap value and reloading it from nonvolatile cells are delegated to a separate store controller through one-cycle request pulses, a busy input and a read-data input. While that controller reports busy, every frame is discarded. All serial pins are brought into the block clock domain through synchronizer stages, so the serial clock may stop entirely between frames.

Top module: `wiper_cmd_decoder`

## Requirements
- R1: After reset the tap register holds 0x200, the control register and power-down flag are 0, the serial output enable is low and neither request pulse is active.
- R2: A frame of 16 bits is taken most significant bit first; bits 13:10 hold the command, bits 9:0 the data, and bits 15:14 are ignored. Command 1 loads the data into the tap register.
- R3: A frame is executed only when its bit count is a non-zero multiple of 16; for longer valid frames the last 16 bits are decoded. Frames of any other length (15, 17, 31, 33) change no register, issue no request and produce no read response.
- R4: Commands 2 (tap), 7 (control register, zero-extended) and 5 (store controller read data) return the value right-justified in a 16-bit word, upper bits 0, most significant bit first on the serial output during the next frame; after any other frame the next frame's output bits are all 0.
- R5: Command 6 loads the low 3 data bits into the control register.
- R6: Command 8 sets the power-down flag to data bit 0 (1 = powered down, 0 = normal).
- R7: Command 3 raises the store request for exactly one clock cycle and leaves the tap register unchanged.
- R8: Command 4 loads the tap register from the store controller read data and raises the refresh request for exactly one clock cycle.
- R9: Command 0 and the unused codes 9 to 15 change no register and issue no request.
- R10: While the store controller reports busy, incoming frames are discarded: no register changes, no request pulses and no read response in the following frame.
- R11: The serial output enable is low whenever frame select is high and high inside a frame; the serial output value changes only after a falling edge of the serial clock, so it is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, sampled on serial clock rise |
| sdo | output | 1 | Serial data out, valid when sdo_en is high |
| sdo_en | output | 1 | Output drive enable for sdo |
| wiper | output | 10 | Tap position register |
| ctrl | output | 3 | Control register |
| shutdown | output | 1 | Power-down flag |
| store_req | output | 1 | One-cycle request to store the tap value |
| refresh_req | output | 1 | One-cycle request marking a reload of the tap |
| store_busy | input | 1 | Store controller is writing nonvolatile cells |
| nv_rdata | input | 10 | Stored value or status from the store controller |

## Verification
The assertions watch, on every cycle, that request pulses last one cycle and never overlap, that a refresh loads exactly the store controller data, that registers hold whenever no frame is accepted, that a busy store window freezes the tap and the shift register, and that the serial output moves only on a falling serial clock edge. Which bit counts are accepted, which 16 bits of a long frame are decoded, the one-frame delay and format of read data, and the effect of each command code can only be shown by the bench's directed frames, which compare registers and the captured output stream against values worked out from the requirements.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP      = 4'd0,
      CMD_WR_TAP   = 4'd1,
      CMD_RD_TAP   = 4'd2,
      CMD_STORE    = 4'd3,
      CMD_REFRESH  = 4'd4,
      CMD_RD_NV    = 4'd5,
      CMD_WR_CTRL  = 4'd6,
      CMD_RD_CTRL  = 4'd7,
      CMD_PWR_DOWN = 4'd8
   } cmd_e;

endpackage

// File: rtl/wcd_sync.sv
module wcd_sync #(
   parameter int          STAGES  = 2,
   parameter int          N       = 3,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("wcd_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [N-1:0] chain [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end

      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/wcd_rx.sv
module wcd_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              busy_i,
   output logic [WORD_W-1:0] word_o,
   output logic              frame_ok_o,
   output logic              frame_end_o,
   output logic              in_frame_o,
   output logic              sclk_fall_o
);

   localparam int              CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic             cs_q, sclk_q;
   logic             cs_fall, cs_rise, sclk_rise;
   logic [CNT_W-1:0] cnt;
   logic             full;
   logic             lock;
   logic [WORD_W-1:0] sr;

   assign cs_fall     = cs_q & ~cs_n_s;
   assign cs_rise     = ~cs_q & cs_n_s;
   assign sclk_rise   = ~sclk_q & sclk_s & ~cs_n_s;
   assign sclk_fall_o = sclk_q & ~sclk_s & ~cs_n_s;
   assign in_frame_o  = ~cs_n_s;
   assign word_o      = sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q        <= 1'b1;
         sclk_q      <= 1'b0;
         cnt         <= '0;
         full        <= 1'b0;
         lock        <= 1'b0;
         sr          <= '0;
         frame_ok_o  <= 1'b0;
         frame_end_o <= 1'b0;
      end else begin
         cs_q        <= cs_n_s;
         sclk_q      <= sclk_s;
         frame_ok_o  <= 1'b0;
         frame_end_o <= 1'b0;
         if (cs_fall) begin
            cnt  <= '0;
            full <= 1'b0;
            lock <= busy_i;
         end else if (!cs_n_s) begin
            if (busy_i) lock <= 1'b1;
            if (sclk_rise && !lock && !busy_i) begin
               sr <= {sr[WORD_W-2:0], sdi_s};
               if (cnt == LAST) begin
                  cnt  <= '0;
                  full <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
         if (cs_rise) begin
            frame_end_o <= 1'b1;
            frame_ok_o  <= !lock && !busy_i && full && (cnt == '0);
         end
      end
   end

   // shift register frozen once the frame has seen a busy store
   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !cs_fall) |=> $stable(sr)) else $error("lock let shift move"); // R10

   AST_OK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok_o |-> frame_end_o) else $error("accept outside frame end"); // R3

endmodule

// File: rtl/wcd_regs.sv
module wcd_regs
   import wcd_pkg::*;
#(
   parameter int              WORD_W    = 16,
   parameter int              DATA_W    = 10,
   parameter int              CTRL_W    = 3,
   parameter logic [DATA_W-1:0] TAP_RST = 10'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_ok_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [DATA_W-1:0] nv_rdata_i,
   output logic [DATA_W-1:0] tap_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              pwr_dn_o,
   output logic              store_req_o,
   output logic              refresh_req_o,
   output logic              rd_hit_o,
   output logic [WORD_W-1:0] rd_word_o
);

   localparam int PAD_W = WORD_W - DATA_W;
   localparam int CPAD_W = DATA_W - CTRL_W;

   logic [CMD_W-1:0]  cmd;
   logic [DATA_W-1:0] dat;
   logic [DATA_W-1:0] rd_val;

   assign cmd = word_i[CMD_W+DATA_W-1:DATA_W];
   assign dat = word_i[DATA_W-1:0];

   if (WORD_W > CMD_W + DATA_W) begin : g_lead
      logic unused_lead;
      assign unused_lead = ^word_i[WORD_W-1:CMD_W+DATA_W];
   end

   always_comb begin
      rd_hit_o = 1'b0;
      rd_val   = '0;
      case (cmd)
         CMD_RD_TAP:  begin rd_hit_o = 1'b1; rd_val = tap_o; end
         CMD_RD_NV:   begin rd_hit_o = 1'b1; rd_val = nv_rdata_i; end
         CMD_RD_CTRL: begin rd_hit_o = 1'b1; rd_val = {{CPAD_W{1'b0}}, ctrl_o}; end
         default:     ;
      endcase
   end

   assign rd_word_o = {{PAD_W{1'b0}}, rd_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_o         <= TAP_RST;
         ctrl_o        <= '0;
         pwr_dn_o      <= 1'b0;
         store_req_o   <= 1'b0;
         refresh_req_o <= 1'b0;
      end else begin
         store_req_o   <= 1'b0;
         refresh_req_o <= 1'b0;
         if (frame_ok_i) begin
            case (cmd)
               CMD_WR_TAP:   tap_o <= dat;
               CMD_STORE:    store_req_o <= 1'b1;
               CMD_REFRESH:  begin
                  tap_o         <= nv_rdata_i;
                  refresh_req_o <= 1'b1;
               end
               CMD_WR_CTRL:  ctrl_o <= dat[CTRL_W-1:0];
               CMD_PWR_DOWN: pwr_dn_o <= dat[0];
               default:      ;
            endcase
         end
      end
   end

   AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      store_req_o |=> !store_req_o) else $error("store pulse too long"); // R7

   AST_REFRESH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req_o |=> !refresh_req_o) else $error("refresh pulse too long"); // R8

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_req_o, refresh_req_o})) else $error("requests overlap"); // R9

   AST_REFRESH_LOADS_NV: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req_o |-> (tap_o == $past(nv_rdata_i))) else $error("refresh data wrong"); // R8

   AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok_i |=> ($stable(tap_o) && $stable(ctrl_o) && $stable(pwr_dn_o)))
      else $error("register moved without frame"); // R3

endmodule

// File: rtl/wcd_tx.sv
module wcd_tx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_frame_i,
   input  logic              sclk_fall_i,
   input  logic              frame_end_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word_i,
   output logic              sdo_o,
   output logic              sdo_en_o
);

   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (frame_end_i) begin
         sr <= load_i ? load_word_i : '0;
      end else if (in_frame_i && sclk_fall_i) begin
         sr <= {sr[WORD_W-2:0], 1'b0};
      end
   end

   assign sdo_o    = sr[WORD_W-1];
   assign sdo_en_o = in_frame_i;

   AST_SDO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame_i && !sclk_fall_i && !frame_end_i) |=> $stable(sdo_o))
      else $error("sdo moved without falling edge"); // R11

endmodule

// File: rtl/wiper_cmd_decoder.sv
module wiper_cmd_decoder
   import wcd_pkg::*;
#(
   parameter int                WORD_W      = 16,
   parameter int                DATA_W      = 10,
   parameter int                CTRL_W      = 3,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] TAP_RST     = 10'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_en,
   output logic [DATA_W-1:0] wiper,
   output logic [CTRL_W-1:0] ctrl,
   output logic              shutdown,
   output logic              store_req,
   output logic              refresh_req,
   input  logic              store_busy,
   input  logic [DATA_W-1:0] nv_rdata
);

   if (WORD_W < CMD_W + DATA_W) begin : g_bad_word
      $error("wiper_cmd_decoder: WORD_W too small for command and data");
   end
   if (CTRL_W < 1 || CTRL_W >= DATA_W) begin : g_bad_ctrl
      $error("wiper_cmd_decoder: CTRL_W must be 1..DATA_W-1");
   end
   if ((WORD_W & (WORD_W - 1)) != 0) begin : g_bad_pow2
      $error("wiper_cmd_decoder: WORD_W must be a power of two");
   end

   logic [2:0]        pins_s;
   logic              cs_n_s, sclk_s, sdi_s;
   logic [WORD_W-1:0] word;
   logic              frame_ok, frame_end, in_frame, sclk_fall;
   logic              rd_hit;
   logic [WORD_W-1:0] rd_word;

   wcd_sync #(
      .STAGES  (SYNC_STAGES),
      .N       (3),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     (pins_s)
   );

   assign {cs_n_s, sclk_s, sdi_s} = pins_s;

   wcd_rx #(.WORD_W(WORD_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (cs_n_s),
      .sclk_s      (sclk_s),
      .sdi_s       (sdi_s),
      .busy_i      (store_busy),
      .word_o      (word),
      .frame_ok_o  (frame_ok),
      .frame_end_o (frame_end),
      .in_frame_o  (in_frame),
      .sclk_fall_o (sclk_fall)
   );

   wcd_regs #(
      .WORD_W  (WORD_W),
      .DATA_W  (DATA_W),
      .CTRL_W  (CTRL_W),
      .TAP_RST (TAP_RST)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_ok_i    (frame_ok),
      .word_i        (word),
      .nv_rdata_i    (nv_rdata),
      .tap_o         (wiper),
      .ctrl_o        (ctrl),
      .pwr_dn_o      (shutdown),
      .store_req_o   (store_req),
      .refresh_req_o (refresh_req),
      .rd_hit_o      (rd_hit),
      .rd_word_o     (rd_word)
   );

   wcd_tx #(.WORD_W(WORD_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_frame_i  (in_frame),
      .sclk_fall_i (sclk_fall),
      .frame_end_i (frame_end),
      .load_i      (frame_ok && rd_hit),
      .load_word_i (rd_word),
      .sdo_o       (sdo),
      .sdo_en_o    (sdo_en)
   );

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (store_busy && $past(store_busy)) |=> ($stable(wiper) && !store_req && !refresh_req))
      else $error("busy window let a command through"); // R10

endmodule

// File: tb/wiper_cmd_decoder_tb.sv
module wiper_cmd_decoder_tb;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo, sdo_en;
   logic [9:0] wiper;
   logic [2:0] ctrl;
   logic       shutdown, store_req, refresh_req;
   logic       store_busy = 1'b0;
   logic [9:0] nv_rdata = 10'h000;

   int checks = 0;
   int errors = 0;
   int st_cnt = 0;
   int rf_cnt = 0;
   logic [63:0] got;
   logic        edge_bad = 1'b0;
   logic        en_bad = 1'b0;

   always #4 clk = ~clk;

   wiper_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_en(sdo_en), .wiper(wiper), .ctrl(ctrl),
      .shutdown(shutdown), .store_req(store_req), .refresh_req(refresh_req),
      .store_busy(store_busy), .nv_rdata(nv_rdata)
   );

   always @(posedge clk) begin
      if (store_req) st_cnt++;
      if (refresh_req) rf_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [1:0] lead, input logic [3:0] cmd,
                                      input logic [9:0] dat);
      return {48'd0, lead, cmd, dat};
   endfunction

   task automatic run_frame(input logic [63:0] bits, input int n);
      logic b;
      got = '0;
      @(negedge clk) cs_n = 1'b0;
      for (int i = n - 1; i >= 0; i--) begin
         sdi = bits[i];
         repeat (HALF) @(negedge clk);
         b = sdo;
         if (sdo_en !== 1'b1) en_bad = 1'b1;
         got = {got[62:0], b};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         if (sdo !== b) edge_bad = 1'b1;
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 wiper", 32'(wiper), 32'h200);
      check("R1 ctrl", 32'(ctrl), 0);
      check("R1 shutdown", 32'(shutdown), 0);
      check("R1 sdo_en", 32'(sdo_en), 0);
      check("R1 requests", 32'({store_req, refresh_req}), 0);
   endtask

   task automatic t_write;
      run_frame(mk(2'b00, 4'd1, 10'h155), 16);
      check("R2 write tap", 32'(wiper), 32'h155);
      run_frame(mk(2'b11, 4'd1, 10'h0AA), 16);
      check("R2 lead bits ignored", 32'(wiper), 32'h0AA);
   endtask

   task automatic t_reads;
      run_frame(mk(2'b00, 4'd2, 10'h3FF), 16);
      check("R4 no response after write", got[31:0], 0);
      run_frame(mk(2'b00, 4'd7, 10'h000), 16);
      check("R4 tap read next frame", got[31:0], 32'h00AA);
      run_frame(mk(2'b00, 4'd0, 10'h000), 16);
      check("R4 ctrl read before write", got[31:0], 0);
      nv_rdata = 10'h2C3;
      run_frame(mk(2'b00, 4'd5, 10'h000), 16);
      run_frame(mk(2'b00, 4'd0, 10'h000), 16);
      check("R4 nv read", got[31:0], 32'h02C3);
   endtask

   task automatic t_ctrl;
      run_frame(mk(2'b00, 4'd6, 10'h3FD), 16);
      check("R5 ctrl write", 32'(ctrl), 32'h5);
      run_frame(mk(2'b00, 4'd7, 10'h000), 16);
      run_frame(mk(2'b00, 4'd0, 10'h000), 16);
      check("R5 R4 ctrl read back", got[31:0], 32'h0005);
   endtask

   task automatic t_shutdown;
      run_frame(mk(2'b00, 4'd8, 10'h001), 16);
      check("R6 power down", 32'(shutdown), 1);
      run_frame(mk(2'b00, 4'd8, 10'h3FE), 16);
      check("R6 normal", 32'(shutdown), 0);
   endtask

   task automatic t_store;
      int s0;
      s0 = st_cnt;
      run_frame(mk(2'b00, 4'd3, 10'h000), 16);
      check("R7 store pulse cycles", 32'(st_cnt - s0), 1);
      check("R7 tap kept", 32'(wiper), 32'h0AA);
   endtask

   task automatic t_refresh;
      int r0;
      r0 = rf_cnt;
      nv_rdata = 10'h123;
      run_frame(mk(2'b00, 4'd4, 10'h000), 16);
      check("R8 refresh tap", 32'(wiper), 32'h123);
      check("R8 refresh pulse cycles", 32'(rf_cnt - r0), 1);
   endtask

   task automatic t_nop;
      int s0, r0;
      s0 = st_cnt;
      r0 = rf_cnt;
      run_frame(mk(2'b00, 4'd0, 10'h3FF), 16);
      run_frame(mk(2'b00, 4'd12, 10'h000), 16);
      run_frame(mk(2'b00, 4'd15, 10'h3FF), 16);
      run_frame(mk(2'b00, 4'd9, 10'h001), 16);
      check("R9 tap", 32'(wiper), 32'h123);
      check("R9 ctrl", 32'(ctrl), 32'h5);
      check("R9 shutdown", 32'(shutdown), 0);
      check("R9 no requests", 32'((st_cnt - s0) + (rf_cnt - r0)), 0);
   endtask

   task automatic t_length;
      run_frame({32'd0, mk(2'b00, 4'd1, 10'h011)} << 16 | mk(2'b00, 4'd1, 10'h2EE), 32);
      check("R3 32-bit last word", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd1, 10'h0F0), 15);
      check("R3 15-bit rejected", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd1, 10'h0F0), 17);
      check("R3 17-bit rejected", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd1, 10'h0F0), 31);
      check("R3 31-bit rejected", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd1, 10'h0F0), 33);
      check("R3 33-bit rejected", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd2, 10'h000), 31);
      run_frame(mk(2'b00, 4'd0, 10'h000), 16);
      check("R3 rejected read silent", got[31:0], 0);
   endtask

   task automatic t_busy;
      int s0;
      s0 = st_cnt;
      @(negedge clk) store_busy = 1'b1;
      run_frame(mk(2'b00, 4'd1, 10'h001), 16);
      check("R10 write blocked", 32'(wiper), 32'h2EE);
      run_frame(mk(2'b00, 4'd3, 10'h000), 16);
      check("R10 store blocked", 32'(st_cnt - s0), 0);
      run_frame(mk(2'b00, 4'd2, 10'h000), 16);
      @(negedge clk) store_busy = 1'b0;
      repeat (4) @(negedge clk);
      run_frame(mk(2'b00, 4'd0, 10'h000), 16);
      check("R10 read blocked", got[31:0], 0);
      run_frame(mk(2'b00, 4'd1, 10'h001), 16);
      check("R10 write after busy", 32'(wiper), 32'h001);
   endtask

   task automatic t_pins;
      check("R11 sdo_en idle", 32'(sdo_en), 0);
      check("R11 sdo_en in frame", 32'(en_bad), 0);
      check("R11 sdo stable while sclk high", 32'(edge_bad), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write();
      t_reads();
      t_ctrl();
      t_shutdown();
      t_store();
      t_refresh();
      t_nop();
      t_length();
      t_busy();
      t_pins();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule